// File: doc/BRIEF.md
# Reset and Power-Mode Controller

This block sits beside a microcontroller core and decides when the core runs, sleeps or is held in reset. It filters the raw reset pin so that only a pulse lasting a set number of machine cycles becomes an internal reset. It gates the CPU clock, the peripheral clock and the oscillator according to the current power mode. It also decides which events end each low-power mode.

Software enters idle or power-down with a one-cycle request pulse. In idle only the CPU clock is stopped, and the peripherals keep running. Idle ends on an enabled interrupt or on the reset pin. Power-down stops the oscillator and every clock, and only a qualified reset ends it. The oscillator is stopped in power-down, so the reset filter then counts ticks of an always-on reference instead of machine-cycle ticks.

A reset that ends idle lets the CPU run for a short time before the internal reset takes hold. During that window the block raises a RAM write-inhibit. Port writes are not blocked. Every flop runs on one always-on clock, and both tick inputs are single-cycle enables in that clock domain.

Top module: `rpm_ctrl`

## Requirements
- R1: `core_rst` rises on the clock edge that samples the QUAL_MC-th qualifying tick seen while `rst_pin` has stayed high. A low sample of `rst_pin` clears the tick count. `core_rst` falls on the edge after `rst_pin` is sampled low.
- R2: A qualifying tick is `mc_tick` while `osc_en` is high and `ref_tick` while `osc_en` is low. The other tick input has no effect on the reset filter.
- R3: In run mode with `core_rst` low, an `idle_req` pulse enters idle on the next edge. Idle means `cpu_clk_en`=0, `per_clk_en`=1 and `osc_en`=1.
- R4: In run mode with `core_rst` low, a `pd_req` pulse enters power-down on the next edge, with all three enables at 0. Power-down wins when both requests arrive in the same cycle.
- R5: In idle, `irq_pending` high with `rst_pin` low returns the block to run mode on the next edge, with all enables at 1.
- R6: In power-down, `irq_pending` has no effect. The block returns to run mode only on the edge after `core_rst` rises.
- R7: In idle, `rst_pin` high opens a wake window on the next edge, with `cpu_clk_en`=1 and `ram_wr_inhibit`=1. The window closes to run mode on the edge after `core_rst` rises.
- R8: If `rst_pin` is sampled low inside the wake window before qualification, the block returns to idle on the next edge and `ram_wr_inhibit` drops.
- R9: While `core_rst` is high, and in any mode other than run, `idle_req` and `pd_req` are ignored.
- R10: After `por_n` is released the block is in run mode, with all enables at 1 and both `core_rst` and `ram_wr_inhibit` at 0.
- R11: In idle, `rst_pin` high takes precedence over `irq_pending` in the same cycle and opens the wake window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock for all state |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | Raw external reset pin, synchronised, active high |
| mc_tick | input | 1 | One-cycle pulse per machine cycle from the oscillator divider |
| ref_tick | input | 1 | One-cycle pulse from the always-on reference |
| idle_req | input | 1 | Software request pulse for idle |
| pd_req | input | 1 | Software request pulse for power-down |
| irq_pending | input | 1 | Any enabled interrupt pending |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| core_rst | output | 1 | Qualified internal reset |
| ram_wr_inhibit | output | 1 | Blocks internal RAM writes during the wake window |

## Verification
The bench builds the block with QUAL_MC=3 rather than the default of 2. This shows that the filter length is not hard-wired, and it leaves room for pulses that are one tick short of qualifying. Machine and reference ticks are dense in the bench, so a reset qualifies within a few cycles. This lets random runs reach power-down exits, wake windows that qualify and wake windows that abort, all within a short run.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_WAKE  = 2'd2,
    PM_PDOWN = 2'd3
  } pm_state_t;
endpackage

// File: rtl/rpm_rst_qual.sv
module rpm_rst_qual #(
  parameter int QUAL_MC = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin,
  input  logic tick,
  output logic rst_q
);
  localparam int CW = (QUAL_MC > 1) ? $clog2(QUAL_MC) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUAL_MC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt   <= '0;
      rst_q <= 1'b0;
    end else if (!rst_pin) begin
      cnt   <= '0;
      rst_q <= 1'b0;
    end else if (tick && !rst_q) begin
      if (cnt == LAST) begin
        cnt   <= '0;
        rst_q <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_rise_needs_pin_R1: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_q) |-> $past(rst_pin));
  assert_low_pin_clears_R1: assert property (@(posedge clk) disable iff (!por_n)
    !rst_pin |=> !rst_q);
endmodule

// File: rtl/rpm_mode_fsm.sv
module rpm_mode_fsm
  import rpm_pkg::*;
(
  input  logic      clk,
  input  logic      por_n,
  input  logic      rst_pin,
  input  logic      rst_q,
  input  logic      idle_req,
  input  logic      pd_req,
  input  logic      irq_pending,
  output pm_state_t state
);
  pm_state_t nxt;

  always_comb begin
    nxt = state;
    if (rst_q) begin
      nxt = PM_RUN;
    end else begin
      unique case (state)
        PM_RUN: begin
          if (pd_req)        nxt = PM_PDOWN;
          else if (idle_req) nxt = PM_IDLE;
        end
        PM_IDLE: begin
          if (rst_pin)          nxt = PM_WAKE;
          else if (irq_pending) nxt = PM_RUN;
        end
        PM_WAKE: begin
          if (!rst_pin) nxt = PM_IDLE;
        end
        PM_PDOWN: nxt = PM_PDOWN;
        default:  nxt = PM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) state <= PM_RUN;
    else        state <= nxt;
  end

  assert_pd_sticky_R6: assert property (@(posedge clk) disable iff (!por_n)
    (state == PM_PDOWN && !rst_q) |=> state == PM_PDOWN);
  assert_wake_from_idle_R7: assert property (@(posedge clk) disable iff (!por_n)
    $changed(state) && state == PM_WAKE |-> $past(state) == PM_IDLE);
endmodule

// File: rtl/rpm_clk_ctl.sv
module rpm_clk_ctl
  import rpm_pkg::*;
(
  input  pm_state_t state,
  output logic      cpu_en,
  output logic      per_en,
  output logic      osc_on,
  output logic      ram_inh
);
  always_comb begin
    cpu_en  = (state == PM_RUN) || (state == PM_WAKE);
    per_en  = (state != PM_PDOWN);
    osc_on  = (state != PM_PDOWN);
    ram_inh = (state == PM_WAKE);
  end
endmodule

// File: rtl/rpm_ctrl.sv
module rpm_ctrl
  import rpm_pkg::*;
#(
  parameter int QUAL_MC = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin,
  input  logic mc_tick,
  input  logic ref_tick,
  input  logic idle_req,
  input  logic pd_req,
  input  logic irq_pending,
  output logic cpu_clk_en,
  output logic per_clk_en,
  output logic osc_en,
  output logic core_rst,
  output logic ram_wr_inhibit
);
  pm_state_t state;
  logic      qual_tick;

  // while the oscillator is stopped, the reset filter counts reference ticks
  assign qual_tick = osc_en ? mc_tick : ref_tick;

  rpm_rst_qual #(.QUAL_MC(QUAL_MC)) u_qual (
    .clk     (clk),
    .por_n   (por_n),
    .rst_pin (rst_pin),
    .tick    (qual_tick),
    .rst_q   (core_rst)
  );

  rpm_mode_fsm u_fsm (
    .clk         (clk),
    .por_n       (por_n),
    .rst_pin     (rst_pin),
    .rst_q       (core_rst),
    .idle_req    (idle_req),
    .pd_req      (pd_req),
    .irq_pending (irq_pending),
    .state       (state)
  );

  rpm_clk_ctl u_clk (
    .state   (state),
    .cpu_en  (cpu_clk_en),
    .per_en  (per_clk_en),
    .osc_on  (osc_en),
    .ram_inh (ram_wr_inhibit)
  );

  assert_pd_all_off_R4: assert property (@(posedge clk) disable iff (!por_n)
    !osc_en |-> (!cpu_clk_en && !per_clk_en));
  assert_inhibit_runs_cpu_R7: assert property (@(posedge clk) disable iff (!por_n)
    ram_wr_inhibit |-> cpu_clk_en);
  assert_idle_entry_R3: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_clk_en && !ram_wr_inhibit && !core_rst && idle_req && !pd_req)
      |=> (!cpu_clk_en && per_clk_en));
  assert_irq_no_wake_pd_R6: assert property (@(posedge clk) disable iff (!por_n)
    (!osc_en && !core_rst) |=> !osc_en);
endmodule

// File: tb/tb_rpm_ctrl.sv
module tb_rpm_ctrl;
  localparam int Q = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic por_n, rst_pin, mc_tick, ref_tick, idle_req, pd_req, irq_pending;
  logic cpu_clk_en, per_clk_en, osc_en, core_rst, ram_wr_inhibit;

  rpm_ctrl #(.QUAL_MC(Q)) dut (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .mc_tick(mc_tick),
    .ref_tick(ref_tick), .idle_req(idle_req), .pd_req(pd_req),
    .irq_pending(irq_pending), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .osc_en(osc_en), .core_rst(core_rst), .ram_wr_inhibit(ram_wr_inhibit)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model: 0 run, 1 idle, 2 wake window, 3 power-down
  int m_st  = 0;
  int m_cnt = 0;
  bit m_rq  = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string mode_tag(input int s);
    case (s)
      1: return "R3";
      2: return "R7";
      3: return "R4";
      default: return "R10";
    endcase
  endfunction

  function automatic int next_mode(input int s, input bit rq, input bit pin,
                                   input bit ir, input bit pr, input bit iq);
    if (rq) return 0;
    case (s)
      0: return pr ? 3 : (ir ? 1 : 0);
      1: return pin ? 2 : (iq ? 0 : 1);
      2: return pin ? 2 : 1;
      default: return 3;
    endcase
  endfunction

  task automatic check_model();
    chk(mode_tag(m_st), "cpu_clk_en", int'(cpu_clk_en), int'(m_st == 0 || m_st == 2));
    chk(mode_tag(m_st), "per_clk_en", int'(per_clk_en), int'(m_st != 3));
    chk(mode_tag(m_st), "osc_en", int'(osc_en), int'(m_st != 3));
    chk("R1", "core_rst", int'(core_rst), int'(m_rq));
    chk("R8", "ram_wr_inhibit", int'(ram_wr_inhibit), int'(m_st == 2));
  endtask

  task automatic cyc(input bit pin, input bit mc, input bit rf,
                     input bit ir, input bit pr, input bit iq);
    bit tk;
    int ns;
    @(negedge clk);
    check_model();
    rst_pin = pin; mc_tick = mc; ref_tick = rf;
    idle_req = ir; pd_req = pr; irq_pending = iq;
    tk = (m_st != 3) ? mc : rf;          // R2 tick source
    ns = next_mode(m_st, m_rq, pin, ir, pr, iq);
    if (!pin) begin
      m_cnt = 0; m_rq = 0;
    end else if (tk && !m_rq) begin
      if (m_cnt == Q - 1) begin m_rq = 1; m_cnt = 0; end
      else m_cnt++;
    end
    m_st = ns;
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit pin;
    void'($urandom(32'h1c3a_5e07));
    por_n = 0; rst_pin = 0; mc_tick = 0; ref_tick = 0;
    idle_req = 0; pd_req = 0; irq_pending = 0;
    repeat (3) @(posedge clk);
    #1;
    // R10: state straight after power-on reset
    chk("R10", "cpu_clk_en", int'(cpu_clk_en), 1);
    chk("R10", "osc_en", int'(osc_en), 1);
    chk("R10", "core_rst", int'(core_rst), 0);
    chk("R10", "ram_wr_inhibit", int'(ram_wr_inhibit), 0);
    @(negedge clk); por_n = 1;

    // R3 then R5: idle entry and interrupt exit
    cyc(0,0,0,1,0,0); settle();
    chk("R3", "cpu_clk_en in idle", int'(cpu_clk_en), 0);
    chk("R3", "per_clk_en in idle", int'(per_clk_en), 1);
    cyc(0,0,0,0,0,1); settle();
    chk("R5", "cpu_clk_en after irq", int'(cpu_clk_en), 1);

    // R1: pulse one tick short, twice, never qualifies
    for (int k = 0; k < Q - 1; k++) cyc(1,1,0,0,0,0);
    cyc(0,1,0,0,0,0);
    for (int k = 0; k < Q - 1; k++) cyc(1,1,0,0,0,0);
    settle();
    chk("R1", "core_rst short pulse", int'(core_rst), 0);
    cyc(1,1,0,0,0,0); settle();
    chk("R1", "core_rst at last tick", int'(core_rst), 1);
    // R9: requests ignored while reset held
    cyc(1,0,0,1,1,0); settle();
    chk("R9", "cpu_clk_en under reset", int'(cpu_clk_en), 1);
    chk("R9", "osc_en under reset", int'(osc_en), 1);
    cyc(0,0,0,0,0,0); settle();
    chk("R1", "core_rst after pin low", int'(core_rst), 0);

    // R4: both requests, power-down wins
    cyc(0,0,0,1,1,0); settle();
    chk("R4", "osc_en", int'(osc_en), 0);
    chk("R4", "per_clk_en", int'(per_clk_en), 0);
    // R6: interrupts ignored in power-down
    for (int k = 0; k < 4; k++) cyc(0,1,1,0,0,1);
    settle();
    chk("R6", "osc_en after irq", int'(osc_en), 0);
    // R2: machine ticks ignored while oscillator is off
    for (int k = 0; k < Q + 2; k++) cyc(1,1,0,0,0,0);
    settle();
    chk("R2", "core_rst from mc ticks in pd", int'(core_rst), 0);
    for (int k = 0; k < Q; k++) cyc(1,0,1,0,0,0);
    settle();
    chk("R2", "core_rst from ref ticks", int'(core_rst), 1);
    cyc(1,0,0,0,0,0); settle();
    chk("R6", "osc_en after qualified reset", int'(osc_en), 1);
    cyc(0,0,0,0,0,0);

    // R7 and R8: wake window, aborted then qualified
    cyc(0,0,0,1,0,0);
    cyc(1,0,0,0,0,0); settle();
    chk("R7", "ram_wr_inhibit in window", int'(ram_wr_inhibit), 1);
    chk("R7", "cpu_clk_en in window", int'(cpu_clk_en), 1);
    cyc(0,0,0,0,0,0); settle();
    chk("R8", "ram_wr_inhibit after abort", int'(ram_wr_inhibit), 0);
    chk("R8", "cpu_clk_en back in idle", int'(cpu_clk_en), 0);
    cyc(1,0,0,0,0,0);
    for (int k = 0; k < Q; k++) cyc(1,1,0,0,0,0);
    settle();
    chk("R7", "inhibit overlaps reset", int'(ram_wr_inhibit), 1);
    cyc(1,0,0,0,0,0); settle();
    chk("R7", "inhibit clears in run", int'(ram_wr_inhibit), 0);
    cyc(0,0,0,0,0,0);

    // R11: reset pin beats interrupt in idle
    cyc(0,0,0,1,0,0);
    cyc(1,0,0,0,0,1); settle();
    chk("R11", "ram_wr_inhibit", int'(ram_wr_inhibit), 1);
    cyc(0,0,0,0,0,1);
    cyc(0,0,0,0,0,1);

    // constrained random, checked against the model every cycle
    pin = 0;
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(9) == 0) pin = ~pin;
      cyc(pin, $urandom_range(2) == 0, $urandom_range(3) == 0,
          $urandom_range(9) == 0, $urandom_range(19) == 0, $urandom_range(7) == 0);
    end
    cyc(0,0,0,0,0,0);
    finish_run();
  end
endmodule